// File: doc/BRIEF.md
# Round-Robin FIFO-to-Controller Word Mover

This block sits between a dual-channel serial controller and the byte-wide FIFOs that buffer each channel. The controller raises a word request on one of four lines: receive for channel 0, receive for channel 1, transmit for channel 0 and transmit for channel 1. The block grants one single-word handshake at a time. A receive word takes a byte off the controller data bus and writes it into that channel's receive FIFO. A transmit word pops a byte from that channel's transmit FIFO and writes it to the controller. A request is passed over without acknowledge when its FIFO cannot take part: the receive FIFO is full, or the transmit FIFO is empty.

The controller data bus is shared with host accesses. A host access is admitted only between words. Once it has started, no word starts until the host access completes and the host is told with a one-cycle done pulse. The arbiter needs no configuration. A second instance can serve another controller with no coupling to the first.

The sequencer has seven states. IDLE goes to HOST when a host request is pending, otherwise to GRANT when some request is eligible, otherwise it stays in IDLE. Each word then runs GRANT → ACK → MOVE → DROP → IDLE. HOST → HDONE → IDLE carries a host access.

Top module: `dma_rr_arbiter`

## Requirements
- R1: While reset is asserted, and after it until a request is presented, all acknowledges, FIFO strobes, controller strobes and `host_done` are low.
- R2: Slots are numbered 0 = Rx ch0, 1 = Rx ch1, 2 = Tx ch0, 3 = Tx ch1 (`dreq`/`dack` bit index). With every slot eligible, words are served one per grant in the order 0, 1, 2, 3, then repeating.
- R3: A transmit slot whose `txf_empty` bit is 1 gets no acknowledge and no `txf_rd` pulse, and the other slots are served in its place.
- R4: A receive slot whose `rxf_full` bit is 1 gets no acknowledge and no `rxf_wr` pulse. It is served again once the full flag clears.
- R5: A word occupies four cycles after the idle cycle in which it is chosen: one grant cycle with no acknowledge, then two cycles with `dack` high, then one cycle with `dack` low. The FIFO and controller strobes pulse only in the second acknowledge cycle. A receive word raises `ctl_rd` and `rxf_wr[c]`, with `rxf_wdata` equal to `ctl_rdata`. A transmit word raises `txf_rd[c]` and `ctl_wr`, with `ctl_wdata` equal to byte c of `txf_rdata` (bits c*8+7..c*8).
- R6: A request held active is served word after word. Once it is dropped before an idle point, it gets no further words.
- R7: A host access waits for any word in progress to finish and takes priority over a new word at the idle point. It drives `ctl_rd` (when `host_we` = 0) or `ctl_wr` with `ctl_wdata` = `host_wdata` for one cycle. `host_done` pulses in the next cycle, with `host_rdata` holding the byte read. Words resume afterwards. The host holds `host_req` until it sees `host_done`.
- R8: At most one `dack` bit is high at any time, and none is high during a host access.
- R9: After a word, the search for the next slot starts at the slot after the one just served, so a skipped slot does not stall the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dreq | input | 4 | Word requests from the controller, slot-indexed |
| dack | output | 4 | Word acknowledges to the controller, slot-indexed |
| rxf_full | input | 2 | Receive FIFO full flag per channel |
| rxf_wr | output | 2 | Receive FIFO write strobe per channel |
| rxf_wdata | output | 8 | Byte written into receive FIFOs |
| txf_empty | input | 2 | Transmit FIFO empty flag per channel |
| txf_rd | output | 2 | Transmit FIFO read strobe per channel |
| txf_rdata | input | 16 | Head bytes of the transmit FIFOs, channel c in bits c*8+7..c*8 |
| ctl_rdata | input | 8 | Controller data bus, read direction |
| ctl_wdata | output | 8 | Controller data bus, write direction |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wr | output | 1 | Controller write strobe |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte captured by the last host read |
| host_done | output | 1 | One-cycle host completion pulse |

## Verification
The hardest case to reach is a host request that lands in the middle of a word while all four slots stay requested. The host must be held off through the remaining handshake cycles, then beat the next grant at the idle point, and the rotation must resume where it stopped. The stimulus keeps all requests high, raises `host_req` just after a word's strobe has been seen, and compares every cycle against a behavioural model of the sequencer. It also checks the wait length and the order of words served before and after the host access. Pointer continuity across skipped slots is reached by first serving a single slot alone and then opening all four.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT,
        ST_ACK,
        ST_MOVE,
        ST_DROP,
        ST_HOST,
        ST_HDONE
    } xfer_state_t;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 4,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  ok,
    input  logic [SW-1:0] ptr,
    output logic          any,
    output logic [SW-1:0] pick
);

    // Walk from ptr downwards in distance so the nearest eligible slot wins.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            automatic int idx = (int'(ptr) + k) % N;
            if (ok[idx]) begin
                any  = 1'b1;
                pick = idx[SW-1:0];
            end
        end
    end

endmodule

// File: rtl/word_path.sv
module word_path #(
    parameter int CH = 2,
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic            move,
    input  logic            host,
    input  logic [SW-1:0]   slot,
    input  logic            host_we,
    input  logic [DW-1:0]   host_wdata,
    input  logic [CH*DW-1:0] txf_rdata,
    input  logic [DW-1:0]   ctl_rdata,
    output logic [CH-1:0]   rxf_wr,
    output logic [CH-1:0]   txf_rd,
    output logic [DW-1:0]   rxf_wdata,
    output logic [DW-1:0]   ctl_wdata,
    output logic            ctl_rd,
    output logic            ctl_wr
);

    logic          is_rx;
    logic [DW-1:0] tx_byte;

    assign is_rx = (slot < SW'(CH));

    for (genvar c = 0; c < CH; c++) begin : g_chan
        assign rxf_wr[c] = move && (slot == SW'(c));
        assign txf_rd[c] = move && (slot == SW'(CH + c));
    end

    always_comb begin
        tx_byte = '0;
        for (int c = 0; c < CH; c++) begin
            if (slot == SW'(CH + c)) tx_byte = txf_rdata[c*DW +: DW];
        end
    end

    assign rxf_wdata = ctl_rdata;
    assign ctl_wdata = host ? host_wdata : tx_byte;
    assign ctl_rd    = (move && is_rx)  || (host && !host_we);
    assign ctl_wr    = (move && !is_rx) || (host && host_we);

endmodule

// File: rtl/dma_rr_arbiter.sv
module dma_rr_arbiter #(
    parameter int CH = 2,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*CH-1:0]   dreq,
    output logic [2*CH-1:0]   dack,
    input  logic [CH-1:0]     rxf_full,
    output logic [CH-1:0]     rxf_wr,
    output logic [DW-1:0]     rxf_wdata,
    input  logic [CH-1:0]     txf_empty,
    output logic [CH-1:0]     txf_rd,
    input  logic [CH*DW-1:0]  txf_rdata,
    input  logic [DW-1:0]     ctl_rdata,
    output logic [DW-1:0]     ctl_wdata,
    output logic              ctl_rd,
    output logic              ctl_wr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_done
);
    import dma_rr_pkg::*;

    localparam int N  = 2 * CH;
    localparam int SW = $clog2(N);

    xfer_state_t   state, nxt;
    logic [SW-1:0] ptr, slot, pick;
    logic [N-1:0]  ok;
    logic          any, move, host;

    // Eligibility: receive slots need room, transmit slots need data.
    for (genvar s = 0; s < N; s++) begin : g_ok
        if (s < CH) begin : g_rx
            assign ok[s] = dreq[s] && !rxf_full[s];
        end else begin : g_tx
            assign ok[s] = dreq[s] && !txf_empty[s-CH];
        end
    end

    rr_pick #(.N(N), .SW(SW)) u_pick (
        .ok   (ok),
        .ptr  (ptr),
        .any  (any),
        .pick (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (host_req) nxt = ST_HOST;
                else if (any) nxt = ST_GRANT;
            end
            ST_GRANT: nxt = ST_ACK;
            ST_ACK:   nxt = ST_MOVE;
            ST_MOVE:  nxt = ST_DROP;
            ST_DROP:  nxt = ST_IDLE;
            ST_HOST:  nxt = ST_HDONE;
            ST_HDONE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            slot <= '0;
        end else if (state == ST_IDLE && !host_req && any) begin
            slot <= pick;
            ptr  <= (pick == SW'(N - 1)) ? '0 : pick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            host_rdata <= '0;
        else if (state == ST_HOST && !host_we) host_rdata <= ctl_rdata;
    end

    always_comb begin
        dack      = '0;
        move      = 1'b0;
        host      = 1'b0;
        host_done = 1'b0;
        unique case (state)
            ST_ACK:   dack = N'(1) << slot;
            ST_MOVE: begin
                dack = N'(1) << slot;
                move = 1'b1;
            end
            ST_HOST:  host = 1'b1;
            ST_HDONE: host_done = 1'b1;
            default: ;
        endcase
    end

    word_path #(.CH(CH), .DW(DW), .SW(SW)) u_path (
        .move       (move),
        .host       (host),
        .slot       (slot),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .txf_rdata  (txf_rdata),
        .ctl_rdata  (ctl_rdata),
        .rxf_wr     (rxf_wr),
        .txf_rd     (txf_rd),
        .rxf_wdata  (rxf_wdata),
        .ctl_wdata  (ctl_wdata),
        .ctl_rd     (ctl_rd),
        .ctl_wr     (ctl_wr)
    );

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack)); // R8

    AST_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|rxf_wr || |txf_rd) |-> (dack != '0)); // R5

    AST_ACK_FALL_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|dack) |-> $past(|rxf_wr || |txf_rd)); // R5

    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (dack == '0 && $past(ctl_rd || ctl_wr))); // R7

    for (genvar c = 0; c < CH; c++) begin : g_gate_chk
        AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dack[CH+c]) |-> $past(!txf_empty[c] && dreq[CH+c], 2)); // R3
        AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dack[c]) |-> $past(!rxf_full[c] && dreq[c], 2)); // R4
    end

endmodule

// File: tb/dma_rr_arbiter_test.sv
`timescale 1ns/1ps
module dma_rr_arbiter_test;
    localparam int CH = 2;
    localparam int DW = 8;
    localparam int N  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] dreq = '0;
    logic [N-1:0] dack;
    logic [CH-1:0] rxf_full = '0, rxf_wr, txf_empty = '0, txf_rd;
    logic [DW-1:0] rxf_wdata, ctl_wdata, host_rdata;
    logic [CH*DW-1:0] txf_rdata = 16'h2B1A;
    logic [DW-1:0] ctl_rdata = 8'h5C;
    logic ctl_rd, ctl_wr, host_done;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [DW-1:0] host_wdata = '0;

    always #2.5 clk = ~clk;

    dma_rr_arbiter #(.CH(CH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack(dack),
        .rxf_full(rxf_full), .rxf_wr(rxf_wr), .rxf_wdata(rxf_wdata),
        .txf_empty(txf_empty), .txf_rd(txf_rd), .txf_rdata(txf_rdata),
        .ctl_rdata(ctl_rdata), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
        .host_req(host_req), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_done(host_done)
    );

    int n_chk = 0, n_bad = 0;
    int served[$];
    int exp_q[$];
    int ack_seen[N];

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 grant, 2/3 acknowledge, 4 release, 5 host, 6 host done
    int m_st = 0, m_ptr = 0, m_slot = 0;

    function automatic bit elig(int s);
        if (s < CH) return dreq[s] && !rxf_full[s];
        return dreq[s] && !txf_empty[s-CH];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_slot = 0;
        end else begin
            case (m_st)
                0: begin
                    if (host_req) m_st = 5;
                    else begin
                        for (int k = 0; k < N; k++) begin
                            int s;
                            s = (m_ptr + k) % N;
                            if (m_st == 0 && elig(s)) begin
                                m_slot = s; m_ptr = (s + 1) % N; m_st = 1;
                            end
                        end
                    end
                end
                1: m_st = 2;
                2: m_st = 3;
                3: m_st = 4;
                5: m_st = 6;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] e_dack;
        logic [CH-1:0] e_rxw, e_txr;
        logic e_rd, e_wr;
        e_dack = (m_st == 2 || m_st == 3) ? N'(1) << m_slot : '0;
        e_rxw = (m_st == 3 && m_slot < CH) ? CH'(1) << m_slot : '0;
        e_txr = (m_st == 3 && m_slot >= CH) ? CH'(1) << (m_slot - CH) : '0;
        e_rd = (m_st == 3 && m_slot < CH) || (m_st == 5 && !host_we);
        e_wr = (m_st == 3 && m_slot >= CH) || (m_st == 5 && host_we);
        chk(dack == e_dack, "R2", "dack", dack, e_dack);
        chk(rxf_wr == e_rxw, "R5", "rxf_wr", rxf_wr, e_rxw);
        chk(txf_rd == e_txr, "R5", "txf_rd", txf_rd, e_txr);
        chk(ctl_rd == e_rd && ctl_wr == e_wr, "R7", "ctl_rd/wr", {ctl_rd, ctl_wr}, {e_rd, e_wr});
        chk(host_done == (m_st == 6), "R7", "host_done", host_done, m_st == 6);
        chk($countones(dack) <= 1, "R8", "dack onehot", dack, 0);
        for (int c = 0; c < CH; c++) begin
            if (rxf_wr[c]) begin
                served.push_back(c);
                chk(rxf_wdata == ctl_rdata, "R5", "rxf_wdata", rxf_wdata, ctl_rdata);
            end
            if (txf_rd[c]) begin
                served.push_back(CH + c);
                chk(ctl_wdata == txf_rdata[c*DW +: DW], "R5", "ctl_wdata tx", ctl_wdata, txf_rdata[c*DW +: DW]);
            end
        end
        if (m_st == 5 && host_we)
            chk(ctl_wdata == host_wdata, "R7", "ctl_wdata host", ctl_wdata, host_wdata);
        for (int s = 0; s < N; s++) if (dack[s]) ack_seen[s]++;
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_words(input int n);
        int lim;
        lim = 0;
        while (served.size() < n && lim < 200) begin
            step();
            lim++;
        end
        chk(served.size() >= n, "R6", "words served", served.size(), n);
    endtask

    task automatic expect_seq(input string req);
        chk(served.size() == exp_q.size(), req, "word count", served.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < served.size(); i++)
            chk(served[i] == exp_q[i], req, $sformatf("slot at word %0d", i), served[i], exp_q[i]);
    endtask

    task automatic clear_log();
        served.delete();
        for (int s = 0; s < N; s++) ack_seen[s] = 0;
    endtask

    task automatic host_access(input bit we, input logic [DW-1:0] wd, input int max_wait);
        int cnt;
        cnt = 0;
        host_req = 1'b1; host_we = we; host_wdata = wd;
        while (!host_done && cnt < 20) begin
            step();
            cnt++;
        end
        chk(host_done == 1'b1 && cnt <= max_wait, "R7", "host wait cycles", cnt, max_wait);
        if (!we) chk(host_rdata == ctl_rdata, "R7", "host_rdata", host_rdata, ctl_rdata);
        host_req = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        step(2);
        // R1: outputs quiet in reset
        chk(dack == '0 && rxf_wr == '0 && txf_rd == '0 && !ctl_rd && !ctl_wr && !host_done,
            "R1", "outputs in reset", {dack, rxf_wr, txf_rd}, 0);
        rst_n = 1'b1;
        step(3);
        chk(dack == '0 && !ctl_rd && !ctl_wr && !host_done, "R1", "outputs after reset", dack, 0);

        // R2: full rotation, twice
        clear_log();
        dreq = 4'hF;
        wait_words(8);
        dreq = '0;
        step(10);
        exp_q = '{0, 1, 2, 3, 0, 1, 2, 3};
        expect_seq("R2");
        chk(served.size() == 8, "R6", "no words after drop", served.size(), 8);

        // R9: pointer continues after the last served slot
        clear_log();
        dreq = 4'b0010;
        wait_words(1);
        dreq = '0;
        step(4);
        clear_log();
        dreq = 4'hF;
        wait_words(4);
        dreq = '0;
        step(6);
        exp_q = '{2, 3, 0, 1};
        expect_seq("R9");

        // R3: empty transmit FIFO skipped
        txf_empty = 2'b01;
        clear_log();
        dreq = 4'hF;
        wait_words(6);
        dreq = '0;
        step(6);
        exp_q = '{3, 0, 1, 3, 0, 1};
        expect_seq("R3");
        chk(ack_seen[2] == 0, "R3", "dack on empty tx slot", ack_seen[2], 0);
        txf_empty = '0;

        // R4: full receive FIFO skipped, then resumes
        rxf_full = 2'b10;
        clear_log();
        dreq = 4'b0011;
        wait_words(3);
        chk(ack_seen[1] == 0, "R4", "dack on full rx slot", ack_seen[1], 0);
        rxf_full = '0;
        wait_words(5);
        dreq = '0;
        step(6);
        chk(served.size() >= 4 && served[0] == 0 && served[1] == 0 && served[2] == 0,
            "R4", "rx0 repeated while rx1 full", served.size(), 3);
        chk(served.size() >= 4 && served[3] == 1, "R4", "rx1 served after clear",
            served.size() >= 4 ? served[3] : -1, 1);

        // R7: host access during continuous words
        clear_log();
        ctl_rdata = 8'hA5;
        dreq = 4'hF;
        wait_words(1);
        host_access(1'b0, 8'h00, 6);
        host_access(1'b1, 8'h77, 6);
        begin
            int base;
            base = served.size();
            wait_words(base + 2);
        end
        dreq = '0;
        step(6);
        host_access(1'b0, 8'h00, 2);
        chk(served.size() >= 3, "R7", "words resumed after host", served.size(), 3);

        step(5);
        summary();
        $finish;
    end

endmodule